// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a chip. It owns the sixteen-state test controller, driven by a test clock and a mode-select line. It also holds a three-bit instruction register, a one-bit bypass stage and a 32-bit identification register. The instruction that is currently in force picks which data path sits between the serial input and the serial output. That path is the bypass stage, the identification register, or a boundary chain that lies outside this block.

For the core, the block gives level outputs for the external-test, sample, clamp and high-impedance modes, and a force-disable line that holds every output driver off while high-impedance is in force. For each of the two user instructions it gives a one-cycle strobe in Update-DR. For the outside boundary chain it gives capture, shift and update strobes, a serial feed to the chain, and a serial return from it. The serial output is launched on the falling test-clock edge. Its enable is high only while data or instruction bits are being shifted.

Top module: `tap_ctrl`

## Requirements
- R1: A high `test_rst` at a rising test-clock edge, or five consecutive rising edges with `tms` high from any state, puts the controller in Test-Logic-Reset. That makes IDCODE the active instruction and drives all mode outputs low.
- R2: State changes follow the standard sixteen-state graph on rising edges of the test clock, including the Pause and Exit2 detour that resumes shifting without a new capture.
- R3: In Capture-IR the instruction shifter loads 3'b001. Instruction bits shift out and in least significant bit first.
- R4: The opcode map is EXTEST=000, IDCODE=001, SAMPLE=010, CLAMP=011, HIGHZ=100, USER1=101, USER2=110 and BYPASS=111. The active instruction changes only on the edge that leaves Update-IR.
- R5: Under IDCODE, Capture-DR loads 32'h00008143, which then shifts out least significant bit first.
- R6: BYPASS, CLAMP, HIGHZ, USER1 and USER2 select the one-bit bypass stage. It captures 0, so an N-bit scan returns a leading 0 followed by the input delayed by one bit.
- R7: EXTEST and SAMPLE select the outside chain. `chain_capture`, `chain_shift` and `chain_update` are high only in Capture-DR, Shift-DR and Update-DR respectively, and only under those instructions. `chain_si` carries `tdi`, and `tdo` carries `chain_so`.
- R8: `mode_extest`, `mode_sample`, `mode_clamp` and `mode_highz` are each high exactly while their instruction is active. `force_disable` is high exactly while HIGHZ is active.
- R9: `user1_strobe` or `user2_strobe` is high for the single Update-DR cycle when USER1 or USER2 is active.
- R10: `tdo` and `tdo_oe` change on the falling test-clock edge. `tdo_oe` is high only in Shift-IR and Shift-DR, and `tdo` is 0 outside them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| test_rst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Mode select sampled on rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge launched |
| tdo_oe | output | 1 | Output enable for tdo |
| chain_capture | output | 1 | Boundary chain capture strobe |
| chain_shift | output | 1 | Boundary chain shift strobe |
| chain_update | output | 1 | Boundary chain update strobe |
| chain_si | output | 1 | Serial feed into boundary chain |
| chain_so | input | 1 | Serial return from boundary chain |
| mode_extest | output | 1 | External-test mode active |
| mode_sample | output | 1 | Sample mode active |
| mode_clamp | output | 1 | Clamp mode active |
| mode_highz | output | 1 | High-impedance mode active |
| force_disable | output | 1 | Hold all output drivers disabled |
| user1_strobe | output | 1 | Update pulse for first user instruction |
| user2_strobe | output | 1 | Update pulse for second user instruction |

## Verification
Each opcode is loaded in turn and scanned with several data words. Bypass paths give a one-bit-delayed echo, the identification path gives the fixed 32-bit word, and chain paths give the chain model's captured byte, so a wrong path selection shows up as a wrong returned word. A scan split by a Pause-DR detour separates the full state graph from a shortened one. An instruction inspected while still in Exit1-IR and Update-IR separates a correct late update from an early one. Reset is approached both by the reset pin and by a run of five TMS-high clocks, and both must return the identification word.

// File: rtl/tap_ctrl_pkg.sv
package tap_ctrl_pkg;
  localparam int IR_W = 3;
  typedef logic [IR_W-1:0] opcode_t;

  localparam opcode_t OP_EXTEST = 3'b000;
  localparam opcode_t OP_IDCODE = 3'b001;
  localparam opcode_t OP_SAMPLE = 3'b010;
  localparam opcode_t OP_CLAMP  = 3'b011;
  localparam opcode_t OP_HIGHZ  = 3'b100;
  localparam opcode_t OP_USER1  = 3'b101;
  localparam opcode_t OP_USER2  = 3'b110;
  localparam opcode_t OP_BYPASS = 3'b111;
  localparam opcode_t IR_CAPTURE_VAL = 3'b001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
  } tap_state_t;

  typedef enum logic [1:0] {PATH_BYPASS, PATH_IDCODE, PATH_CHAIN} dr_path_t;

  typedef struct packed {
    logic extest;
    logic sample;
    logic clamp;
    logic highz;
    logic user1;
    logic user2;
  } mode_t;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_ctrl_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: nxt = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   nxt = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: nxt = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      ST_IR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
      default:     nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_RESET;
    else     state <= nxt;
  end

  // run of consecutive TMS-high edges, saturating, for the reset-by-TMS check
  logic [2:0] tms_run;
  always_ff @(posedge tck) begin
    if (rst)                    tms_run <= '0;
    else if (!tms)              tms_run <= '0;
    else if (tms_run != 3'd7)   tms_run <= tms_run + 3'd1;
  end

  AST_TMS_FIVE_RESET: assert property (@(posedge tck) disable iff (rst)
    (tms_run >= 3'd5) |-> (state == ST_RESET)); // R1
  AST_RESET_HOLD: assert property (@(posedge tck) disable iff (rst)
    (state == ST_RESET && tms) |=> (state == ST_RESET)); // R2
  AST_UPD_IR_EXIT: assert property (@(posedge tck) disable iff (rst)
    (state == ST_IR_UPD) |=> (state == ST_IDLE || state == ST_DR_SEL)); // R2
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_ctrl_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  tap_state_t state,
  input  logic       tdi,
  output opcode_t    active,
  output logic       ir_lsb
);
  opcode_t sh;

  always_ff @(posedge tck) begin
    if (rst) begin
      sh     <= IR_CAPTURE_VAL;
      active <= OP_IDCODE;
    end else begin
      case (state)
        ST_RESET:    active <= OP_IDCODE;
        ST_IR_CAP:   sh     <= IR_CAPTURE_VAL;
        ST_IR_SHIFT: sh     <= {tdi, sh[IR_W-1:1]};
        ST_IR_UPD:   active <= sh;
        default: ;
      endcase
    end
  end

  assign ir_lsb = sh[0];

  AST_IR_HOLD: assert property (@(posedge tck) disable iff (rst)
    !(state == ST_IR_UPD || state == ST_RESET) |=> $stable(active)); // R4
  AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (rst)
    (state == ST_IR_CAP) |=> (sh == IR_CAPTURE_VAL)); // R3
endmodule

// File: rtl/tap_decode.sv
module tap_decode
  import tap_ctrl_pkg::*;
(
  input  opcode_t  active,
  output mode_t    mode,
  output dr_path_t path
);
  always_comb begin
    mode = '0;
    path = PATH_BYPASS;
    case (active)
      OP_EXTEST: begin mode.extest = 1'b1; path = PATH_CHAIN;  end
      OP_SAMPLE: begin mode.sample = 1'b1; path = PATH_CHAIN;  end
      OP_IDCODE: path = PATH_IDCODE;
      OP_CLAMP:  mode.clamp = 1'b1;
      OP_HIGHZ:  mode.highz = 1'b1;
      OP_USER1:  mode.user1 = 1'b1;
      OP_USER2:  mode.user2 = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_ctrl_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h00008143
) (
  input  logic       tck,
  input  logic       rst,
  input  tap_state_t state,
  input  dr_path_t   path,
  input  logic       tdi,
  input  logic       chain_so,
  output logic       dr_lsb
);
  logic            byp;
  logic [ID_W-1:0] id_sh;
  logic            cap, shf;

  assign cap = (state == ST_DR_CAP);
  assign shf = (state == ST_DR_SHIFT);

  always_ff @(posedge tck) begin
    if (rst) begin
      byp <= 1'b0;
    end else if (path == PATH_BYPASS) begin
      if (cap)      byp <= 1'b0;
      else if (shf) byp <= tdi;
    end
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      id_sh <= ID_VALUE[ID_W-1:0];
    end else if (path == PATH_IDCODE) begin
      if (cap)      id_sh <= ID_VALUE[ID_W-1:0];
      else if (shf) id_sh <= {tdi, id_sh[ID_W-1:1]};
    end
  end

  always_comb begin
    case (path)
      PATH_IDCODE: dr_lsb = id_sh[0];
      PATH_CHAIN:  dr_lsb = chain_so;
      default:     dr_lsb = byp;
    endcase
  end

  AST_BYPASS_CAPTURE: assert property (@(posedge tck) disable iff (rst)
    (cap && path == PATH_BYPASS) |=> (byp == 1'b0)); // R6
  AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (rst)
    (cap && path == PATH_IDCODE) |=> (id_sh == ID_VALUE[ID_W-1:0])); // R5
endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_ctrl_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h00008143
) (
  input  logic tck,
  input  logic test_rst,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe,
  output logic chain_capture,
  output logic chain_shift,
  output logic chain_update,
  output logic chain_si,
  input  logic chain_so,
  output logic mode_extest,
  output logic mode_sample,
  output logic mode_clamp,
  output logic mode_highz,
  output logic force_disable,
  output logic user1_strobe,
  output logic user2_strobe
);
  tap_state_t state;
  opcode_t    active;
  mode_t      mode;
  dr_path_t   path;
  logic       ir_lsb, dr_lsb, chain_sel;

  tap_fsm u_fsm (.tck(tck), .rst(test_rst), .tms(tms), .state(state));

  tap_ir u_ir (.tck(tck), .rst(test_rst), .state(state), .tdi(tdi),
               .active(active), .ir_lsb(ir_lsb));

  tap_decode u_dec (.active(active), .mode(mode), .path(path));

  tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .rst(test_rst), .state(state), .path(path), .tdi(tdi),
    .chain_so(chain_so), .dr_lsb(dr_lsb));

  assign chain_sel     = (path == PATH_CHAIN);
  assign chain_capture = chain_sel && (state == ST_DR_CAP);
  assign chain_shift   = chain_sel && (state == ST_DR_SHIFT);
  assign chain_update  = chain_sel && (state == ST_DR_UPD);
  assign chain_si      = tdi;

  assign mode_extest   = mode.extest;
  assign mode_sample   = mode.sample;
  assign mode_clamp    = mode.clamp;
  assign mode_highz    = mode.highz;
  assign force_disable = mode.highz;
  assign user1_strobe  = mode.user1 && (state == ST_DR_UPD);
  assign user2_strobe  = mode.user2 && (state == ST_DR_UPD);

  // serial output launched half a cycle after the shift edge
  always_ff @(negedge tck) begin
    if (test_rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      case (state)
        ST_IR_SHIFT: begin tdo <= ir_lsb; tdo_oe <= 1'b1; end
        ST_DR_SHIFT: begin tdo <= dr_lsb; tdo_oe <= 1'b1; end
        default:     begin tdo <= 1'b0;   tdo_oe <= 1'b0; end
      endcase
    end
  end

  AST_CHAIN_ONEHOT: assert property (@(posedge tck) disable iff (test_rst)
    $onehot0({chain_capture, chain_shift, chain_update})); // R7
  AST_MODE_ONEHOT: assert property (@(posedge tck) disable iff (test_rst)
    $onehot0({mode_extest, mode_sample, mode_clamp, mode_highz, user1_strobe, user2_strobe})); // R8
  AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (test_rst)
    tdo_oe |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT)); // R10
  AST_TDO_QUIET: assert property (@(posedge tck) disable iff (test_rst)
    !tdo_oe |-> !tdo); // R10
endmodule

// File: tb/tap_ctrl_tb.sv
module tap_ctrl_tb;
  localparam logic [31:0] ID_EXP   = 32'h00008143;
  localparam logic [7:0]  CHAIN_CAP = 8'hC3;

  logic tck = 1'b0;
  logic test_rst = 1'b1;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_oe, chain_capture, chain_shift, chain_update, chain_si, chain_so;
  logic mode_extest, mode_sample, mode_clamp, mode_highz, force_disable;
  logic user1_strobe, user2_strobe;

  int checks = 0;
  int errors = 0;
  int u1_cnt = 0, u2_cnt = 0, upd_cnt = 0;
  bit finished = 0;

  always #4 tck = ~tck;

  tap_ctrl u_dut (
    .tck(tck), .test_rst(test_rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .chain_capture(chain_capture), .chain_shift(chain_shift), .chain_update(chain_update),
    .chain_si(chain_si), .chain_so(chain_so),
    .mode_extest(mode_extest), .mode_sample(mode_sample), .mode_clamp(mode_clamp),
    .mode_highz(mode_highz), .force_disable(force_disable),
    .user1_strobe(user1_strobe), .user2_strobe(user2_strobe));

  // small stand-in for the outside boundary chain
  logic [7:0] chain_q = 8'h00;
  always_ff @(posedge tck) begin
    if (chain_capture)    chain_q <= CHAIN_CAP;
    else if (chain_shift) chain_q <= {chain_si, chain_q[7:1]};
  end
  assign chain_so = chain_q[0];

  always @(negedge tck) begin
    if (user1_strobe) u1_cnt++;
    if (user2_strobe) u2_cnt++;
    if (chain_update) upd_cnt++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o, output logic e);
    @(negedge tck);
    #1;
    o = tdo;
    e = tdo_oe;
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  task automatic go(input logic m);
    logic o, e;
    step(m, 1'b0, o, e);
  endtask

  task automatic shift_bits(input int n, input logic [63:0] din, output logic [63:0] dout,
                            output bit oe_ok);
    logic o, e;
    dout = '0;
    oe_ok = 1;
    for (int i = 0; i < n; i++) begin
      step((i == n - 1), din[i], o, e);
      dout[i] = o;
      if (e !== 1'b1) oe_ok = 0;
    end
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout,
                         output bit oe_ok);
    go(1); go(0); go(0);
    shift_bits(n, din, dout, oe_ok);
    go(1); go(0);
  endtask

  task automatic scan_ir(input logic [2:0] din, output logic [2:0] dout);
    logic [63:0] d;
    bit ok;
    go(1); go(1); go(0); go(0);
    shift_bits(3, {61'd0, din}, d, ok);
    go(1); go(0);
    dout = d[2:0];
  endtask

  task automatic modes_chk(input string req, input logic [4:0] exp);
    chk(req, {59'd0, mode_extest, mode_sample, mode_clamp, mode_highz, force_disable}, {59'd0, exp});
  endtask

  task automatic t_reset;
    logic [63:0] d;
    bit ok;
    test_rst = 1'b1;
    tms = 1'b1;
    repeat (4) @(posedge tck);
    #1;
    test_rst = 1'b0;
    modes_chk("R1 modes after reset", 5'b00000);
    chk("R10 oe low after reset", {63'd0, tdo_oe}, 64'd0);
    go(0);
    scan_dr(32, 64'h0, d, ok);
    chk("R5 id word after reset", d, {32'd0, ID_EXP});
    chk("R10 oe high through shift", {63'd0, ok}, 64'd1);
  endtask

  task automatic t_ir_capture;
    logic [2:0] c;
    scan_ir(3'b111, c);
    chk("R3 instruction capture pattern", {61'd0, c}, 64'd1);
  endtask

  task automatic t_bypass(input logic [2:0] op, input string req);
    logic [63:0] d;
    logic [2:0] c;
    bit ok;
    scan_ir(op, c);
    scan_dr(8, 64'hA5, d, ok);
    chk(req, d, 64'h4A);
    scan_dr(8, 64'h3C, d, ok);
    chk(req, d, 64'h78);
  endtask

  task automatic t_clamp_highz;
    logic [2:0] c;
    t_bypass(3'b011, "R6 clamp bypass echo");
    modes_chk("R8 clamp mode", 5'b00100);
    scan_ir(3'b100, c);
    modes_chk("R8 highz mode with force disable", 5'b00011);
    t_bypass(3'b100, "R6 highz bypass echo");
  endtask

  task automatic t_user;
    int a1, a2;
    a1 = u1_cnt; a2 = u2_cnt;
    t_bypass(3'b101, "R6 user1 bypass echo");
    chk("R9 user1 strobes", {32'd0, u1_cnt - a1}, 64'd2);
    chk("R9 user2 quiet under user1", {32'd0, u2_cnt - a2}, 64'd0);
    a1 = u1_cnt; a2 = u2_cnt;
    t_bypass(3'b110, "R6 user2 bypass echo");
    chk("R9 user2 strobes", {32'd0, u2_cnt - a2}, 64'd2);
    chk("R9 user1 quiet under user2", {32'd0, u1_cnt - a1}, 64'd0);
    modes_chk("R8 no core mode under user", 5'b00000);
  endtask

  task automatic t_chain(input logic [2:0] op, input logic [4:0] mexp, input string req);
    logic [63:0] d;
    logic [2:0] c;
    bit ok;
    int u;
    scan_ir(op, c);
    modes_chk("R8 chain mode outputs", mexp);
    u = upd_cnt;
    scan_dr(8, 64'h96, d, ok);
    chk(req, d, {56'd0, CHAIN_CAP});
    chk("R7 chain holds shifted data", {56'd0, chain_q}, 64'h96);
    chk("R7 one chain update", {32'd0, upd_cnt - u}, 64'd1);
  endtask

  task automatic t_update_only;
    logic [63:0] d;
    bit ok;
    logic [2:0] c;
    scan_ir(3'b000, c);
    go(1); go(1); go(0); go(0);
    shift_bits(3, 64'h3, d, ok);
    modes_chk("R4 old instruction in Exit1-IR", 5'b10000);
    go(1);
    modes_chk("R4 old instruction in Update-IR", 5'b10000);
    go(0);
    modes_chk("R4 new instruction after Update-IR", 5'b00100);
  endtask

  task automatic t_tms_reset;
    logic [63:0] d;
    logic [2:0] c;
    bit ok;
    scan_ir(3'b100, c);
    repeat (5) go(1);
    modes_chk("R1 modes after five TMS-high", 5'b00000);
    go(0);
    scan_dr(32, 64'h0, d, ok);
    chk("R1 IDCODE active after TMS reset", d, {32'd0, ID_EXP});
  endtask

  task automatic t_pause;
    logic [63:0] a, b;
    logic o, e;
    bit ok;
    go(1); go(0); go(0);
    shift_bits(16, 64'h0, a, ok);
    go(0);
    step(1'b0, 1'b0, o, e);
    chk("R10 oe low in Pause-DR", {63'd0, e}, 64'd0);
    chk("R10 tdo low in Pause-DR", {63'd0, o}, 64'd0);
    go(1); go(0);
    shift_bits(16, 64'h0, b, ok);
    go(1); go(0);
    chk("R2 id word across pause", {32'd0, b[15:0], a[15:0]}, {32'd0, ID_EXP});
  endtask

  task automatic t_pin_reset;
    logic [2:0] c;
    scan_ir(3'b100, c);
    test_rst = 1'b1;
    repeat (2) @(posedge tck);
    #1;
    test_rst = 1'b0;
    modes_chk("R1 pin reset clears highz", 5'b00000);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ir_capture();
    t_bypass(3'b111, "R6 bypass echo");
    t_clamp_highz();
    t_user();
    t_chain(3'b000, 5'b10000, "R7 extest returns chain capture");
    t_chain(3'b010, 5'b01000, "R7 sample returns chain capture");
    t_update_only();
    t_tms_reset();
    t_pause();
    t_pin_reset();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule